// File: doc/BRIEF.md
# Dual-Buffer Frame Receiver with Destination Filter

This block is the receive half of a small memory-mapped Ethernet MAC. Frames arrive one byte per cycle on a stream qualified by a valid strobe and a last-byte marker. The first six bytes are the destination address. A frame is kept if its first byte carries the group bit (0x80) or if all six bytes equal the station address given on an input. Kept frames are written, packed big-endian into 32-bit words, into one of two 2 KB buffers that the host reads over a simple 32-bit slave port.

Each buffer has a control word that holds a "full" status bit and an interrupt-enable bit. When a kept frame ends, its buffer's status bit is set and, if enabled, a single-cycle interrupt pulse is raised. A full buffer is never written again until the host writes its control word with the status bit cleared. A frame that arrives while the selected buffer is full is discarded as lost. With ping-pong mode on, the receiver moves to the other buffer after every stored frame. With it off, only buffer 0 is used. No frame length is recorded, so the host reads the whole buffer.

Top module: `frame_rx_pingpong`

## Requirements
- R1: Host map, by byte offset. Buffer 0 data starts at 0x1000 and buffer 1 data starts at 0x1800. Buffer 0's control word is at 0x17FC and buffer 1's is at 0x1FFC. The global interrupt enable is bit 31 of the word at 0x07F8. A read returns its data on `bus_rdata` in the cycle after `bus_rd`. Any other offset reads as zero and ignores writes.
- R2: A frame is kept when its first byte has bit 7 set, or when bytes 0..5 equal `station_addr[47:40]` .. `station_addr[7:0]` in that order. Any other frame, and any frame shorter than 6 bytes, sets no status, raises no interrupt and leaves the buffer selection unchanged.
- R3: When a kept frame's last byte is accepted, bit 0 (status) of that frame's buffer control word reads 1 from the next cycle on.
- R4: `irq` is high for exactly one cycle: the cycle after a kept frame's last byte. It rises only when bit 3 of that buffer's control word and the global enable bit 31 are both 1.
- R5: With `PINGPONG`=1, the buffer selection toggles after each stored frame, so consecutive kept frames land in alternate buffers, starting with buffer 0.
- R6: With `PINGPONG`=0, every frame is directed to buffer 0.
- R7: If the selected buffer's status bit is 1 at a frame's first byte, the whole frame is lost. It writes no data, sets no status, raises no interrupt and does not toggle the selection. Status stays 1 until the host writes that control word with bit 0 = 0.
- R8: Byte k of a frame is stored in word k/4 of the buffer, in bits [31-8*(k mod 4) -: 8].
- R9: Bytes beyond the first 2044 (0x7FC) are discarded. The frame is still marked received, and the control word is not overwritten.
- R10: After reset, buffer 0 is selected, both control words and the global enable read 0, and `irq` is low.
- R11: A host write to a control word loads bit 3 (interrupt enable) and bit 0 (status) from the write data. If a frame completes in the same cycle for the same buffer, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| station_addr | input | 48 | Station address; bits 47:40 are compared with the first destination byte |
| rx_data | input | 8 | Received frame byte |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| rx_last | input | 1 | This byte ends the frame |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | ADDR_W | Host byte address (word aligned) |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
Three results are checked, and each has a fixed time of arrival. A read's data is due one clock after `bus_rd`. A status bit set by a frame shows up in a read issued at any time after the last byte's clock edge. The interrupt pulse is due exactly in the cycle that follows the last byte's edge. The bench's reference model advances on the same rising edge as the design, using the inputs that were held steady since the previous falling edge. On the following falling edge it compares `irq` every cycle, and it compares `bus_rdata` in any cycle that follows a read. A second instance with ping-pong mode off receives the same stimulus and is checked directly on a few control-word reads.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
  typedef logic [7:0] octet_t;

  // bit positions inside a buffer control word and the global enable word
  localparam int ST_POS  = 0;
  localparam int IE_POS  = 3;
  localparam int GIE_POS = 31;

  localparam int DST_BYTES = 6;

  // source of the registered read data
  typedef enum logic [1:0] {
    RK_REG   = 2'd0,
    RK_BANK0 = 2'd1,
    RK_BANK1 = 2'd2
  } rd_kind_e;

  // big-endian lane: byte 0 of a word sits in the top lane
  function automatic logic [1:0] be_lane(input logic [1:0] k);
    return 2'd3 - k;
  endfunction
endpackage

// File: rtl/fpp_dst_filter.sv
module fpp_dst_filter
  import fpp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] station,
  input  octet_t      byte_in,
  input  logic        valid,
  input  logic        last,
  output logic        pass
);
  logic [2:0] idx_q, idx_d;
  logic       eq_q, eq_d;
  logic       grp_q, grp_d;
  octet_t     ref_b;
  logic       eq_now, grp_now;
  int         sel;

  always_comb begin
    sel     = (idx_q < 3'(DST_BYTES)) ? int'(idx_q) : 0;
    ref_b   = station[8*(DST_BYTES-1-sel) +: 8];
    eq_now  = eq_q & ((idx_q < 3'(DST_BYTES)) ? (byte_in == ref_b) : 1'b1);
    grp_now = (idx_q == 3'd0) ? byte_in[7] : grp_q;
    // decision includes the byte currently on the input
    pass    = (idx_q >= 3'(DST_BYTES-1)) & (grp_now | eq_now);

    idx_d = idx_q;
    eq_d  = eq_q;
    grp_d = grp_q;
    if (last) begin
      idx_d = 3'd0;
      eq_d  = 1'b1;
      grp_d = 1'b0;
    end else begin
      idx_d = (idx_q == 3'(DST_BYTES)) ? idx_q : idx_q + 3'd1;
      eq_d  = eq_now;
      grp_d = grp_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 3'd0;
      eq_q  <= 1'b1;
      grp_q <= 1'b0;
    end else if (valid) begin
      idx_q <= idx_d;
      eq_q  <= eq_d;
      grp_q <= grp_d;
    end
  end
endmodule

// File: rtl/fpp_bank_ram.sv
module fpp_bank_ram
  import fpp_pkg::*;
#(
  parameter int WORDS = 512,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_word,
  input  logic [1:0]    wr_lane,
  input  octet_t        wr_byte,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_word,
  output logic [31:0]   rd_data
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_word][8*wr_lane +: 8] <= wr_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_word];
    end
  end
endmodule

// File: rtl/frame_rx_pingpong.sv
module frame_rx_pingpong
  import fpp_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter bit PINGPONG  = 1'b1,
  parameter int ADDR_W    = $clog2(4*BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [47:0]       station_addr,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int WORDS      = BUF_BYTES / 4;
  localparam int WAW        = $clog2(WORDS);
  localparam int DATA_LIMIT = BUF_BYTES - 4;
  localparam int CNT_W      = $clog2(BUF_BYTES) + 1;
  localparam int BANK_BIT   = $clog2(BUF_BYTES);
  localparam int GIE_OFS    = BUF_BYTES - 8;

  // ---------------- state ----------------
  logic [1:0]       st_q, st_d;
  logic [1:0]       ie_q, ie_d;
  logic             gie_q, gie_d;
  logic             cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fbank_q, fbank_d;
  logic             flost_q, flost_d;
  logic             irq_q, irq_d;
  rd_kind_e         rk_q, rk_d;
  logic [31:0]      rreg_q, rreg_d;

  // ---------------- host decode ----------------
  logic           in_rx, a_bank, is_ctrl, is_gie;
  logic [WAW-1:0] a_word;
  logic [1:0]     host_wr_ctrl;
  logic           unused_bits;

  assign in_rx   = bus_addr[ADDR_W-1];
  assign a_bank  = bus_addr[BANK_BIT];
  assign a_word  = bus_addr[BANK_BIT-1:2];
  assign is_ctrl = in_rx && (a_word == WAW'(WORDS-1));
  assign is_gie  = bus_addr == ADDR_W'(GIE_OFS);
  assign host_wr_ctrl[0] = bus_wr && is_ctrl && !a_bank;
  assign host_wr_ctrl[1] = bus_wr && is_ctrl &&  a_bank;
  assign unused_bits = ^{bus_wdata[30:4], bus_wdata[2:1], bus_addr[1:0]};

  // ---------------- frame control ----------------
  logic pass, first, bank_now, lost_now, room, store_ok, commit;

  fpp_dst_filter u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .station (station_addr),
    .byte_in (rx_data),
    .valid   (rx_valid),
    .last    (rx_last),
    .pass    (pass)
  );

  assign first    = (cnt_q == '0);
  assign bank_now = first ? cur_q : fbank_q;
  assign lost_now = first ? st_q[cur_q] : flost_q;
  assign room     = cnt_q < CNT_W'(DATA_LIMIT);
  assign store_ok = rx_valid && !lost_now && room;
  assign commit   = rx_valid && rx_last && !lost_now && pass;

  // ---------------- buffers ----------------
  logic [31:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    fpp_bank_ram #(.WORDS(WORDS), .AW(WAW)) u_ram (
      .clk     (clk),
      .wr_en   (store_ok && (bank_now == 1'(b))),
      .wr_word (cnt_q[WAW+1:2]),
      .wr_lane (be_lane(cnt_q[1:0])),
      .wr_byte (rx_data),
      .rd_en   (bus_rd && in_rx && !is_ctrl && (a_bank == 1'(b))),
      .rd_word (a_word),
      .rd_data (bank_rd[b])
    );
  end

  // ---------------- next state ----------------
  always_comb begin
    st_d    = st_q;
    ie_d    = ie_q;
    gie_d   = gie_q;
    cur_d   = cur_q;
    cnt_d   = cnt_q;
    fbank_d = fbank_q;
    flost_d = flost_q;
    irq_d   = 1'b0;
    rk_d    = rk_q;
    rreg_d  = rreg_q;

    if (rx_valid) begin
      if (first) begin
        fbank_d = cur_q;
        flost_d = st_q[cur_q];
      end
      if (rx_last)   cnt_d = '0;
      else if (room) cnt_d = cnt_q + CNT_W'(1);
    end

    for (int b = 0; b < 2; b++) begin
      if (host_wr_ctrl[b]) begin
        st_d[b] = bus_wdata[ST_POS];
        ie_d[b] = bus_wdata[IE_POS];
      end
    end
    if (bus_wr && is_gie) gie_d = bus_wdata[GIE_POS];

    if (commit) begin
      st_d[bank_now] = 1'b1;
      irq_d          = ie_q[bank_now] && gie_q;
      if (PINGPONG) cur_d = ~cur_q;
    end

    if (bus_rd) begin
      rreg_d = '0;
      if (in_rx && !is_ctrl) begin
        rk_d = a_bank ? RK_BANK1 : RK_BANK0;
      end else begin
        rk_d = RK_REG;
        if (is_ctrl) begin
          rreg_d[ST_POS] = st_q[a_bank];
          rreg_d[IE_POS] = ie_q[a_bank];
        end else if (is_gie) begin
          rreg_d[GIE_POS] = gie_q;
        end
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      ie_q    <= '0;
      gie_q   <= 1'b0;
      cur_q   <= 1'b0;
      cnt_q   <= '0;
      fbank_q <= 1'b0;
      flost_q <= 1'b0;
      irq_q   <= 1'b0;
      rk_q    <= RK_REG;
      rreg_q  <= '0;
    end else begin
      st_q  <= st_d;
      ie_q  <= ie_d;
      gie_q <= gie_d;
      cur_q <= cur_d;
      irq_q <= irq_d;
      if (rx_valid) begin
        cnt_q   <= cnt_d;
        fbank_q <= fbank_d;
        flost_q <= flost_d;
      end
      if (bus_rd) begin
        rk_q   <= rk_d;
        rreg_q <= rreg_d;
      end
    end
  end

  always_comb begin
    case (rk_q)
      RK_BANK0: bus_rdata = bank_rd[0];
      RK_BANK1: bus_rdata = bank_rd[1];
      default:  bus_rdata = rreg_q;
    endcase
  end

  assign irq = irq_q;
endmodule

// File: rtl/frame_rx_pingpong_chk.sv
module frame_rx_pingpong_chk #(
  parameter bit PINGPONG = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_last,
  input logic       irq,
  input logic [1:0] st_q,
  input logic       cur_q,
  input logic [1:0] host_wr_ctrl
);
  // R4
  irq_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_valid && rx_last));

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  status0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[0] && !host_wr_ctrl[0]) |=> st_q[0]);

  // R7
  status1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[1] && !host_wr_ctrl[1]) |=> st_q[1]);

  // R3
  status0_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[0]) |-> ($past(rx_valid && rx_last) || $past(host_wr_ctrl[0])));

  // R3
  status1_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[1]) |-> ($past(rx_valid && rx_last) || $past(host_wr_ctrl[1])));

  // R6
  always_comb begin
    if (rst_n && !PINGPONG) begin
      fixed_bank_chk: assert (cur_q == 1'b0);
    end
  end
endmodule

bind frame_rx_pingpong frame_rx_pingpong_chk #(.PINGPONG(PINGPONG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .rx_last      (rx_last),
  .irq          (irq),
  .st_q         (st_q),
  .cur_q        (cur_q),
  .host_wr_ctrl (host_wr_ctrl)
);

// File: tb/frame_rx_pingpong_bench.sv
module frame_rx_pingpong_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 2044;
  localparam logic [47:0] STATION = 48'h02_12_34_56_78_9A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_fx;
  logic        irq, irq_fx;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_rx_pingpong u_frame_rx_pingpong (
    .clk(clk), .rst_n(rst_n), .station_addr(STATION),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq(irq));

  frame_rx_pingpong #(.PINGPONG(1'b0)) u_frame_rx_pingpong_fixed (
    .clk(clk), .rst_n(rst_n), .station_addr(STATION),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_fx), .irq(irq_fx));

  int    n_cmp = 0, n_bad = 0;
  string tag = "R10";
  bit    done = 1'b0;

  // ---------------- behavioural reference model ----------------
  logic [7:0]  mb [2][2048];
  logic [7:0]  fq [$];
  bit          m_st [2], m_ie [2];
  bit          m_gie, m_cur, m_first, m_lost, m_bank;
  int          m_cnt;
  bit          m_irq, m_rdchk;
  logic [31:0] m_rd;

  function automatic logic [31:0] model_read(input logic [12:0] a);
    int b, w;
    if (a[12]) begin
      b = int'(a[11]);
      w = int'(a[10:2]);
      if (w == 511) return {28'd0, m_ie[b], 2'b00, m_st[b]};
      return {mb[b][4*w], mb[b][4*w+1], mb[b][4*w+2], mb[b][4*w+3]};
    end
    if (a == 13'h07F8) return {m_gie, 31'd0};
    return 32'd0;
  endfunction

  function automatic bit frame_pass();
    bit eq = 1'b1;
    if (fq.size() < 6) return 1'b0;
    if (fq[0][7]) return 1'b1;
    for (int i = 0; i < 6; i++)
      if (fq[i] != STATION[47-8*i -: 8]) eq = 1'b0;
    return eq;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st[0] = 0; m_st[1] = 0; m_ie[0] = 0; m_ie[1] = 0;
      m_gie = 0; m_cur = 0; m_first = 1; m_lost = 0; m_bank = 0;
      m_cnt = 0; m_irq = 0; m_rdchk = 0;
    end else begin
      bit do_commit;
      do_commit = 0;
      m_irq = 0;
      m_rdchk = bus_rd;
      if (bus_rd) m_rd = model_read(bus_addr);
      if (rx_valid) begin
        if (m_first) begin
          m_lost = m_st[m_cur];
          m_bank = m_cur;
          fq.delete();
        end
        m_first = 0;
        fq.push_back(rx_data);
        if (m_cnt < LIMIT) begin
          if (!m_lost) mb[m_bank][m_cnt] = rx_data;
          m_cnt++;
        end
        if (rx_last) begin
          if (frame_pass() && !m_lost) begin
            do_commit = 1;
            m_irq = m_ie[m_bank] && m_gie;
          end
          m_first = 1;
          m_cnt = 0;
        end
      end
      if (bus_wr) begin
        if (bus_addr == 13'h17FC) begin m_st[0] = bus_wdata[0]; m_ie[0] = bus_wdata[3]; end
        if (bus_addr == 13'h1FFC) begin m_st[1] = bus_wdata[0]; m_ie[1] = bus_wdata[3]; end
        if (bus_addr == 13'h07F8) m_gie = bus_wdata[31];
      end
      if (do_commit) begin
        m_st[m_bank] = 1;
        m_cur = ~m_cur;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s irq: actual %b expected %b at %0t", tag, irq, m_irq, $time);
      end
      if (m_rdchk) begin
        n_cmp++;
        if (rdata !== m_rd) begin
          n_bad++;
          $display("FAIL %s rdata: actual %h expected %h at %0t", tag, rdata, m_rd, $time);
        end
      end
    end
  end

  // ---------------- stimulus tasks (entered at a falling edge) ----------------
  task automatic host_write(input logic [12:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic host_read(input logic [12:0] a);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic fixed_read(input logic [12:0] a, input logic [31:0] exp);
    host_read(a);
    n_cmp++;
    if (rdata_fx !== exp) begin
      n_bad++;
      $display("FAIL R6 fixed-mode read %h: actual %h expected %h", a, rdata_fx, exp);
    end
  endtask

  logic [7:0] tx_q [$];

  task automatic send_frame();
    foreach (tx_q[i]) begin
      rx_valid = 1; rx_data = tx_q[i]; rx_last = (i == tx_q.size() - 1);
      @(negedge clk);
    end
    rx_valid = 0; rx_last = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic build(input logic [47:0] dst, input int len, input int seed);
    tx_q.delete();
    for (int i = 0; i < len; i++)
      tx_q.push_back(i < 6 ? dst[47-8*i -: 8] : 8'(seed + 7*i));
  endtask

  // ---------------- test sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    tag = "R10";
    host_read(13'h17FC); host_read(13'h1FFC); host_read(13'h07F8);

    tag = "R1";
    host_write(13'h07F8, 32'h8000_0000);
    host_write(13'h0100, 32'hFFFF_FFFF);
    host_read(13'h0100); host_read(13'h07F8);
    tag = "R11";
    host_write(13'h17FC, 32'h0000_0008);
    host_write(13'h1FFC, 32'h0000_0008);
    host_read(13'h17FC); host_read(13'h1FFC);

    tag = "R8";   // exact match, R3 and R4 also apply
    build(STATION, 12, 3); send_frame();
    host_read(13'h1000); host_read(13'h1004); host_read(13'h1008);
    tag = "R3"; host_read(13'h17FC);
    fixed_read(13'h17FC, 32'h9);

    tag = "R2";   // one byte off, group bit clear
    build(48'h02_12_34_56_78_9B, 8, 5); send_frame();
    host_read(13'h1FFC);

    tag = "R5";   // broadcast lands in buffer 1
    build(48'hFF_FF_FF_FF_FF_FF, 12, 9); send_frame();
    host_read(13'h1FFC); host_read(13'h1800); host_read(13'h1808);
    fixed_read(13'h1FFC, 32'h8);

    tag = "R7";   // buffer 0 full: frame lost
    build(48'h81_00_00_00_00_01, 8, 11); send_frame();
    host_read(13'h1000); host_read(13'h1004); host_read(13'h17FC);
    host_write(13'h17FC, 32'h0000_0008);
    host_read(13'h17FC);

    tag = "R2";   // group bit alone is enough
    build(48'h81_00_00_00_00_01, 8, 11); send_frame();
    host_read(13'h1000); host_read(13'h1004); host_read(13'h17FC);

    host_write(13'h1FFC, 32'h0);
    build(STATION, 5, 1); send_frame();   // too short: dropped
    host_read(13'h1FFC);

    tag = "R4";   // buffer enable off
    build(STATION, 8, 2); send_frame();
    host_read(13'h1FFC);
    host_write(13'h07F8, 32'h0);           // global enable off
    host_write(13'h17FC, 32'h0000_0008);
    build(STATION, 8, 4); send_frame();
    host_read(13'h17FC);
    host_write(13'h07F8, 32'h8000_0000);

    tag = "R9";   // oversize frame into buffer 1
    host_write(13'h1FFC, 32'h0000_0008);
    build(STATION, 2050, 13); send_frame();
    host_read(13'h1800); host_read(13'h1FF8); host_read(13'h1FFC);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired (tag %s)", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule